// File: doc/BRIEF.md
# DRAM bank decoder and address multiplexer

This block sits between a memory request source and an array of eight DRAM banks. It turns a byte address and an access size into the signals the DRAM array needs: one row strobe, eight byte-lane column strobes and a time-multiplexed address bus. Each bank has a start and an end boundary, an enable, and a geometry code that sets its row and column widths. Configuration software sizes the banks and programs these inputs before any traffic starts. The block treats them as static while requests are in flight.

A request is taken in the idle phase with a valid/ready handshake. The block finds the bank whose boundaries enclose the double-word address. It subtracts that bank's start to get an offset inside the bank, and splits the offset into a column field in the low bits and a row field above it. It then runs a row phase and a column phase, each of programmable length. Column strobes act as byte-lane enables. When error correction or read-modify-write parity is switched on, every column strobe fires for a full double word. An address that no usable bank claims produces a single-cycle error pulse and no strobes.

Top module: `dram_bank_mux`

## Requirements
- R1: The double-word address is the byte address without its low three bits. The in-bank offset is this double-word address minus the selected bank's start. The column field is the offset's low C bits, with C = 9 + column code (codes 0..3 give 9..12 bits). The row field is the next R bits, with R = 9 + row code (codes 0..4 give 9..13 bits). Both fields appear on the 13-bit address bus with all unused upper bits at zero.
- R2: A bank whose row code is above 4, or whose row code is 4 (13 bits) with column code 3 (12 bits), is never selected, whatever its boundaries hold.
- R3: A bank matches when it is enabled, its geometry is valid, and start <= double-word address <= end, with both bounds inclusive. Only the row strobe of the matching bank goes low, on ras_n bit equal to the bank number. When several banks match, the lowest-numbered one is selected.
- R4: A request that matches no bank drives no row or column strobe. It raises dec_err for exactly one cycle, in the cycle after acceptance, and the block stays ready.
- R5: With both error correction and parity off, column strobe bit k (active low) is asserted exactly for the byte lanes k in [low3, low3 + 2^size - 1]. Here low3 is the byte address bits [2:0], and size codes 0/1/2/3 mean 1/2/4/8 bytes. Lanes past 7 are dropped.
- R6: With ecc_en or rmw_par_en high, all eight column strobes are asserted in the column phase, whatever the size and low address bits.
- R7: After an accepted hit, the block holds the row field on the bus with the selected row strobe low and all column strobes high for row_cycles cycles. It then holds the column field with the same row strobe low and the lane strobes low for col_cycles cycles, and then returns to idle. A programmed length of 0 counts as 1.
- R8: Reset, and the idle phase, drive all strobes high (inactive), the bus to zero and req_ready high. req_ready is low during the row and column phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_en | input | 8 | Per-bank enable |
| bank_lo | input | 216 | Per-bank start double-word address, 27 bits each, bank 0 lowest |
| bank_hi | input | 216 | Per-bank end double-word address (inclusive), 27 bits each |
| row_code | input | 24 | Per-bank row width code, 3 bits each |
| col_code | input | 16 | Per-bank column width code, 2 bits each |
| ecc_en | input | 1 | Error correction mode: full double-word accesses |
| rmw_par_en | input | 1 | Read-modify-write parity mode: full double-word accesses |
| row_cycles | input | 4 | Row phase length in cycles (0 means 1) |
| col_cycles | input | 4 | Column phase length in cycles (0 means 1) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 30 | Byte address |
| req_size | input | 2 | Access size code: 2^size bytes |
| ras_n | output | 8 | Per-bank row strobes, active low |
| cas_n | output | 8 | Per-lane column strobes, active low |
| ma | output | 13 | Multiplexed row/column address |
| dec_err | output | 1 | Single-cycle pulse for an unmapped address |

## Verification
The assertions check properties that hold in every cycle. At most one row strobe is low at a time. A column strobe never fires without a row strobe. Idle is electrically quiet. The error pulse never lasts more than a cycle and never comes with a strobe. The row strobe is stable through an access, and the full-width column rule holds in the correcting modes. The arithmetic of the row/column split, the inclusive boundary comparisons, the masking of invalid geometries, the overlap priority, the lane masks and the exact phase lengths depend on the programmed configuration. Only the bench's vectors can show these, because they compare the bus and the strobes against hand-computed values.

// File: rtl/dram_bank_pkg.sv
package dram_bank_pkg;

  localparam int unsigned RCODE_W   = 3;
  localparam int unsigned CCODE_W   = 2;
  localparam int unsigned BASE_BITS = 9;
  localparam logic [RCODE_W-1:0] RCODE_MAX = 3'd4;
  localparam logic [CCODE_W-1:0] CCODE_MAX = 2'd3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ROW  = 2'd1,
    PH_COL  = 2'd2
  } phase_t;

  // Geometry is usable when the row code is in range and the
  // widest row is not paired with the widest column.
  function automatic logic geom_ok(input logic [RCODE_W-1:0] rc,
                                   input logic [CCODE_W-1:0] cc);
    return (rc <= RCODE_MAX) && !((rc == RCODE_MAX) && (cc == CCODE_MAX));
  endfunction

endpackage

// File: rtl/dram_bank_sel.sv
module dram_bank_sel
  import dram_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned DW_W      = 27,
  localparam int unsigned BI_W     = $clog2(NUM_BANKS)
) (
  input  logic [DW_W-1:0]              dw,
  input  logic [NUM_BANKS-1:0]         bank_en,
  input  logic [NUM_BANKS*DW_W-1:0]    bank_lo,
  input  logic [NUM_BANKS*DW_W-1:0]    bank_hi,
  input  logic [NUM_BANKS*RCODE_W-1:0] row_code,
  input  logic [NUM_BANKS*CCODE_W-1:0] col_code,
  output logic                         hit,
  output logic [BI_W-1:0]              idx,
  output logic [DW_W-1:0]              base
);

  logic [NUM_BANKS-1:0] match;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
    logic [DW_W-1:0]    lo_b, hi_b;
    logic [RCODE_W-1:0] rc_b;
    logic [CCODE_W-1:0] cc_b;
    assign lo_b = bank_lo[b*DW_W +: DW_W];
    assign hi_b = bank_hi[b*DW_W +: DW_W];
    assign rc_b = row_code[b*RCODE_W +: RCODE_W];
    assign cc_b = col_code[b*CCODE_W +: CCODE_W];
    assign match[b] = bank_en[b] && geom_ok(rc_b, cc_b) &&
                      (dw >= lo_b) && (dw <= hi_b);
  end

  // Walk from the top so the lowest matching bank is the last to win.
  always_comb begin
    idx  = '0;
    base = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (match[b]) begin
        idx  = BI_W'(b);
        base = bank_lo[b*DW_W +: DW_W];
      end
    end
  end

  assign hit = |match;

endmodule

// File: rtl/dram_addr_split.sv
module dram_addr_split
  import dram_bank_pkg::*;
#(
  parameter int unsigned DW_W = 27,
  parameter int unsigned MA_W = 13
) (
  input  logic [DW_W-1:0]    offset,
  input  logic [RCODE_W-1:0] rc,
  input  logic [CCODE_W-1:0] cc,
  output logic [MA_W-1:0]    row,
  output logic [MA_W-1:0]    col
);

  logic [DW_W-1:0] col_mask, row_mask, above_col;
  int unsigned     col_bits, row_bits;

  always_comb begin
    col_bits  = BASE_BITS + int'(cc);
    row_bits  = BASE_BITS + int'(rc);
    col_mask  = (DW_W'(1) << col_bits) - DW_W'(1);
    row_mask  = (DW_W'(1) << row_bits) - DW_W'(1);
    above_col = offset >> col_bits;
    col       = MA_W'(offset & col_mask);
    row       = MA_W'(above_col & row_mask);
  end

endmodule

// File: rtl/dram_lane_gen.sv
module dram_lane_gen #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned SIZE_W = 2,
  localparam int unsigned LB    = $clog2(LANES)
) (
  input  logic [LB-1:0]     low,
  input  logic [SIZE_W-1:0] size,
  input  logic              force_all,
  output logic [LANES-1:0]  lanes
);

  logic [2*LANES-1:0] span, placed;
  int unsigned        nbytes;

  always_comb begin
    nbytes = 1 << size;
    if (nbytes > LANES) nbytes = LANES;
    span   = ((2*LANES)'(1) << nbytes) - (2*LANES)'(1);
    placed = span << low;
    lanes  = force_all ? '1 : placed[LANES-1:0];
  end

endmodule

// File: rtl/dram_bank_mux.sv
module dram_bank_mux
  import dram_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ADDR_W    = 30,
  parameter int unsigned MA_W      = 13,
  parameter int unsigned LANES     = 8,
  parameter int unsigned SIZE_W    = 2,
  parameter int unsigned PHASE_W   = 4,
  localparam int unsigned LB       = $clog2(LANES),
  localparam int unsigned DW_W     = ADDR_W - LB,
  localparam int unsigned BI_W     = $clog2(NUM_BANKS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_BANKS-1:0]         bank_en,
  input  logic [NUM_BANKS*DW_W-1:0]    bank_lo,
  input  logic [NUM_BANKS*DW_W-1:0]    bank_hi,
  input  logic [NUM_BANKS*RCODE_W-1:0] row_code,
  input  logic [NUM_BANKS*CCODE_W-1:0] col_code,
  input  logic                         ecc_en,
  input  logic                         rmw_par_en,
  input  logic [PHASE_W-1:0]           row_cycles,
  input  logic [PHASE_W-1:0]           col_cycles,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [SIZE_W-1:0]            req_size,
  output logic [NUM_BANKS-1:0]         ras_n,
  output logic [LANES-1:0]             cas_n,
  output logic [MA_W-1:0]              ma,
  output logic                         dec_err
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // Decode path.
  logic [DW_W-1:0]    dw, sel_base, offset;
  logic               sel_hit;
  logic [BI_W-1:0]    sel_idx;
  logic [RCODE_W-1:0] sel_rc;
  logic [CCODE_W-1:0] sel_cc;
  logic [MA_W-1:0]    row_w, col_w;
  logic [LANES-1:0]   lanes_w;

  assign dw = req_addr[ADDR_W-1:LB];

  dram_bank_sel #(.NUM_BANKS(NUM_BANKS), .DW_W(DW_W)) u_sel (
    .dw       (dw),
    .bank_en  (bank_en),
    .bank_lo  (bank_lo),
    .bank_hi  (bank_hi),
    .row_code (row_code),
    .col_code (col_code),
    .hit      (sel_hit),
    .idx      (sel_idx),
    .base     (sel_base)
  );

  assign sel_rc = row_code[sel_idx*RCODE_W +: RCODE_W];
  assign sel_cc = col_code[sel_idx*CCODE_W +: CCODE_W];
  assign offset = dw - sel_base;

  dram_addr_split #(.DW_W(DW_W), .MA_W(MA_W)) u_split (
    .offset (offset),
    .rc     (sel_rc),
    .cc     (sel_cc),
    .row    (row_w),
    .col    (col_w)
  );

  dram_lane_gen #(.LANES(LANES), .SIZE_W(SIZE_W)) u_lane (
    .low       (req_addr[LB-1:0]),
    .size      (req_size),
    .force_all (ecc_en | rmw_par_en),
    .lanes     (lanes_w)
  );

  // Sequencer state.
  phase_t             phase_q, phase_d;
  logic [PHASE_W-1:0] cnt_q, cnt_d;
  logic [BI_W-1:0]    bank_q, bank_d;
  logic [MA_W-1:0]    row_q, row_d, col_q, col_d;
  logic [LANES-1:0]   lanes_q, lanes_d;
  logic               err_q, err_d;
  logic               adv;

  function automatic logic [PHASE_W-1:0] hold_len(input logic [PHASE_W-1:0] n);
    return (n == '0) ? '0 : n - PHASE_W'(1);
  endfunction

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    bank_d  = bank_q;
    row_d   = row_q;
    col_d   = col_q;
    lanes_d = lanes_q;
    err_d   = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          if (sel_hit) begin
            phase_d = PH_ROW;
            cnt_d   = hold_len(row_cycles);
            bank_d  = sel_idx;
            row_d   = row_w;
            col_d   = col_w;
            lanes_d = lanes_w;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      PH_ROW: begin
        if (cnt_q == '0) begin
          phase_d = PH_COL;
          cnt_d   = hold_len(col_cycles);
        end else begin
          cnt_d = cnt_q - PHASE_W'(1);
        end
      end
      PH_COL: begin
        if (cnt_q == '0) phase_d = PH_IDLE;
        else             cnt_d   = cnt_q - PHASE_W'(1);
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign adv = (phase_q != PH_IDLE) || req_valid;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      lanes_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= err_d;
      if (adv) begin
        phase_q <= phase_d;
        cnt_q   <= cnt_d;
        bank_q  <= bank_d;
        row_q   <= row_d;
        col_q   <= col_d;
        lanes_q <= lanes_d;
      end
    end
  end

  // Outputs from registered state.
  logic busy;
  assign busy      = (phase_q != PH_IDLE);
  assign req_ready = !busy;
  assign dec_err   = err_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ras
    assign ras_n[b] = !(busy && (bank_q == BI_W'(b)));
  end

  assign cas_n = (phase_q == PH_COL) ? ~lanes_q : '1;

  always_comb begin
    case (phase_q)
      PH_ROW:  ma = row_q;
      PH_COL:  ma = col_q;
      default: ma = '0;
    endcase
  end

endmodule

// File: rtl/dram_bank_mux_chk.sv
module dram_bank_mux_chk #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned LANES     = 8,
  parameter int unsigned MA_W      = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 ecc_en,
  input logic                 rmw_par_en,
  input logic [NUM_BANKS-1:0] ras_n,
  input logic [LANES-1:0]     cas_n,
  input logic [MA_W-1:0]      ma,
  input logic                 dec_err
);

  AST_ONE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ras_n) <= 1); // R3

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != '1) |-> (ras_n != '1)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((ras_n == '1) && (cas_n == '1) && (ma == '0))); // R8

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |=> !dec_err); // R4

  AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> ((ras_n == '1) && (cas_n == '1) && req_ready)); // R4

  AST_FULL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ((cas_n != '1) && (ecc_en || rmw_par_en)) |-> (cas_n == '0)); // R6

  AST_RAS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((ras_n != '1) && ($past(ras_n) != '1)) |-> $stable(ras_n)); // R7

  AST_ACCEPT_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (dec_err || (ras_n != '1))); // R3

endmodule

bind dram_bank_mux dram_bank_mux_chk #(
  .NUM_BANKS (NUM_BANKS),
  .LANES     (LANES),
  .MA_W      (MA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .ecc_en     (ecc_en),
  .rmw_par_en (rmw_par_en),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .ma         (ma),
  .dec_err    (dec_err)
);

// File: tb/dram_bank_mux_tb.sv
`timescale 1ns/1ps
module dram_bank_mux_tb;

  localparam int NB   = 8;
  localparam int AW   = 30;
  localparam int DWW  = 27;
  localparam int MAW  = 13;
  localparam int NL   = 8;
  localparam int PW   = 4;
  localparam int NVEC = 12;

  // Bank layout (double-word addresses)
  localparam logic [DWW-1:0] LO [NB] = '{27'h0000000, 27'h0040000, 27'h0080000, 27'h0100000,
                                         27'h0200000, 27'h0280000, 27'h0300000, 27'h0400000};
  localparam logic [DWW-1:0] HI [NB] = '{27'h003FFFF, 27'h007FFFF, 27'h00FFFFF, 27'h01FFFFF,
                                         27'h02FFFFF, 27'h03FFFFF, 27'h03FFFFF, 27'h07FFFFF};
  localparam logic [2:0] RC [NB] = '{3'd0, 3'd2, 3'd4, 3'd3, 3'd0, 3'd3, 3'd0, 3'd4};
  localparam logic [1:0] CC [NB] = '{2'd0, 2'd1, 2'd3, 2'd2, 2'd0, 2'd2, 2'd0, 2'd2};

  // {addr[29:0], size[1:0], ecc, par, bank[2:0], err, row[15:0], col[15:0], lanes[7:0]}
  localparam logic [77:0] VEC [NVEC] = '{
    {30'h0000028, 2'd3, 1'b0, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h0005, 8'hFF},
    {30'h000501A, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0, 16'h0005, 16'h0003, 8'h0C},
    {30'h0291A2D, 2'd0, 1'b0, 1'b0, 3'd1, 1'b0, 16'h0048, 16'h0345, 8'h20},
    {30'h0400080, 2'd3, 1'b0, 1'b0, 3'd0, 1'b1, 16'h0000, 16'h0000, 8'h00},
    {30'h0D5E6F4, 2'd2, 1'b0, 1'b0, 3'd3, 1'b0, 16'h0157, 16'h04DE, 8'hF0},
    {30'h1280000, 2'd3, 1'b0, 1'b0, 3'd0, 1'b1, 16'h0000, 16'h0000, 8'h00},
    {30'h1800026, 2'd2, 1'b0, 1'b0, 3'd5, 1'b0, 16'h0100, 16'h0004, 8'hC0},
    {30'h3FFFFF8, 2'd3, 1'b0, 1'b0, 3'd7, 1'b0, 16'h07FF, 16'h07FF, 8'hFF},
    {30'h4000000, 2'd3, 1'b0, 1'b0, 3'd0, 1'b1, 16'h0000, 16'h0000, 8'h00},
    {30'h000000B, 2'd0, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h0001, 8'hFF},
    {30'h0200000, 2'd1, 1'b0, 1'b1, 3'd1, 1'b0, 16'h0000, 16'h0000, 8'hFF},
    {30'h01FFFFE, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0, 16'h01FF, 16'h01FF, 8'hC0}
  };

  logic              clk, rst_n;
  logic [NB-1:0]     bank_en;
  logic [NB*DWW-1:0] bank_lo, bank_hi;
  logic [NB*3-1:0]   row_code;
  logic [NB*2-1:0]   col_code;
  logic              ecc_en, rmw_par_en;
  logic [PW-1:0]     row_cycles, col_cycles;
  logic              req_valid, req_ready;
  logic [AW-1:0]     req_addr;
  logic [1:0]        req_size;
  logic [NB-1:0]     ras_n;
  logic [NL-1:0]     cas_n;
  logic [MAW-1:0]    ma;
  logic              dec_err;

  int n_checks, n_fail;
  bit done;

  dram_bank_mux u_dut (
    .clk(clk), .rst_n(rst_n), .bank_en(bank_en), .bank_lo(bank_lo), .bank_hi(bank_hi),
    .row_code(row_code), .col_code(col_code), .ecc_en(ecc_en), .rmw_par_en(rmw_par_en),
    .row_cycles(row_cycles), .col_cycles(col_cycles), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size), .ras_n(ras_n),
    .cas_n(cas_n), .ma(ma), .dec_err(dec_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(ras_n == '1, req, "idle ras_n", 32'(ras_n), 32'hFF);
    chk(cas_n == '1, req, "idle cas_n", 32'(cas_n), 32'hFF);
    chk(ma == '0, req, "idle ma", 32'(ma), 32'h0);
    chk(req_ready == 1'b1, req, "idle ready", 32'(req_ready), 32'h1);
  endtask

  // Issue a request at a falling edge; returns at the falling edge after acceptance.
  task automatic issue(input logic [AW-1:0] a, input logic [1:0] sz);
    req_addr  = a;
    req_size  = sz;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input int i);
    logic [AW-1:0] a;
    logic [1:0]    sz;
    logic          e, p, er;
    logic [2:0]    bk;
    logic [15:0]   rw, cl;
    logic [7:0]    ln;
    logic [NB-1:0] exp_ras;
    {a, sz, e, p, bk, er, rw, cl, ln} = VEC[i];
    ecc_en     = e;
    rmw_par_en = p;
    exp_ras    = ~(NB'(1) << bk);
    issue(a, sz);
    if (er) begin
      chk(dec_err == 1'b1, "R4", $sformatf("vec %0d err pulse", i), 32'(dec_err), 32'h1);
      chk(ras_n == '1 && cas_n == '1, "R4", $sformatf("vec %0d no strobes", i),
          32'({ras_n, cas_n}), 32'hFFFF);
      chk(req_ready == 1'b1, "R4", $sformatf("vec %0d stays ready", i), 32'(req_ready), 32'h1);
      @(negedge clk);
      chk(dec_err == 1'b0, "R4", $sformatf("vec %0d err one cycle", i), 32'(dec_err), 32'h0);
      if (i == 3)
        chk(dec_err == 1'b0, "R2", "invalid geometry bank skipped", 32'(dec_err), 32'h0);
    end else begin
      // Row phase, cycle 1 of 2
      chk(ras_n == exp_ras, "R3", $sformatf("vec %0d ras_n", i), 32'(ras_n), 32'(exp_ras));
      chk(ma == rw[MAW-1:0], "R1", $sformatf("vec %0d row", i), 32'(ma), 32'(rw));
      chk(cas_n == '1, "R7", $sformatf("vec %0d cas in row", i), 32'(cas_n), 32'hFF);
      chk(req_ready == 1'b0, "R8", $sformatf("vec %0d busy ready", i), 32'(req_ready), 32'h0);
      @(negedge clk);
      chk(ma == rw[MAW-1:0] && cas_n == '1, "R7", $sformatf("vec %0d row cycle 2", i),
          32'({ma, cas_n}), 32'({rw[MAW-1:0], 8'hFF}));
      @(negedge clk);
      // Column phase, one cycle
      chk(ma == cl[MAW-1:0], "R1", $sformatf("vec %0d col", i), 32'(ma), 32'(cl));
      chk(cas_n == ~ln, (e || p) ? "R6" : "R5", $sformatf("vec %0d lanes", i),
          32'(cas_n), 32'(~ln));
      chk(ras_n == exp_ras, "R7", $sformatf("vec %0d ras in col", i), 32'(ras_n), 32'(exp_ras));
      @(negedge clk);
      chk_idle("R7");
    end
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
    ecc_en = 1'b0; rmw_par_en = 1'b0;
    row_cycles = 4'd2; col_cycles = 4'd1;
    bank_en = 8'b1110_1111;
    for (int b = 0; b < NB; b++) begin
      bank_lo[b*DWW +: DWW] = LO[b];
      bank_hi[b*DWW +: DWW] = HI[b];
      row_code[b*3 +: 3]    = RC[b];
      col_code[b*2 +: 2]    = CC[b];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R8");
    chk(dec_err == 1'b0, "R8", "reset dec_err", 32'(dec_err), 32'h0);

    for (int i = 0; i < NVEC; i++) run_vec(i);

    // Zero-length phases count as one cycle (R7)
    ecc_en = 1'b0; rmw_par_en = 1'b0;
    row_cycles = 4'd0; col_cycles = 4'd0;
    issue(30'h0000028, 2'd3);
    chk(ma == 13'h0 && ras_n == 8'hFE && cas_n == '1, "R7", "zero row len in row",
        32'({ma, ras_n, cas_n}), 32'({13'h0, 8'hFE, 8'hFF}));
    @(negedge clk);
    chk(ma == 13'h5 && cas_n == 8'h00, "R7", "zero len in col", 32'({ma, cas_n}),
        32'({13'h5, 8'h00}));
    @(negedge clk);
    chk_idle("R7");

    // Longer phases: three row cycles, two column cycles (R7)
    row_cycles = 4'd3; col_cycles = 4'd2;
    issue(30'h0291A2D, 2'd0);
    for (int c = 0; c < 3; c++) begin
      chk(ma == 13'h048 && cas_n == '1, "R7", $sformatf("long row cycle %0d", c),
          32'({ma, cas_n}), 32'({13'h048, 8'hFF}));
      @(negedge clk);
    end
    for (int c = 0; c < 2; c++) begin
      chk(ma == 13'h345 && cas_n == 8'hDF, "R7", $sformatf("long col cycle %0d", c),
          32'({ma, cas_n}), 32'({13'h345, 8'hDF}));
      @(negedge clk);
    end
    chk_idle("R7");

    // Enabling the invalid-geometry bank still gives no decode (R2)
    row_cycles = 4'd1; col_cycles = 4'd1;
    issue(30'h0400080, 2'd3);
    chk(dec_err == 1'b1 && ras_n == '1, "R2", "13x12 bank never selected",
        32'({dec_err, ras_n}), 32'({1'b1, 8'hFF}));
    @(negedge clk);

    // Reset in the middle of an access clears strobes at once (R8)
    issue(30'h0000028, 2'd3);
    chk(ras_n == 8'hFE, "R3", "bank 0 before reset", 32'(ras_n), 32'hFE);
    #1 rst_n = 1'b0;
    #0.5;
    chk(ras_n == '1 && cas_n == '1 && ma == '0, "R8", "async reset quiets outputs",
        32'({ras_n, cas_n}), 32'hFFFF);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule